// File: doc/BRIEF.md
# Guest Interruptibility State Tracker

This block keeps the blocking state that a virtualized processor core needs to decide which pending events it may deliver to a guest. It watches instruction retirement, tagged with a small kind code. It also watches NMI and SMI delivery and the current execution mode. From these it keeps a four-bit state word and presents five blocking flags to the event arbiter: external interrupts, NMI, SMI, INIT and SIPI.

Two kinds of blocking are tracked. One-instruction shadows follow an interrupt-enable instruction or a stack-segment load, and they expire on the next retired instruction whatever the clock is doing. Persistent blocks follow SMI and NMI delivery and last until a return-from-SMM or an interrupt-return retires. On a VM entry the hypervisor's copy of the word is loaded in one cycle. The live word is always visible on a save port, so VM exit logic can capture it at any moment.

Top module: `guest_intr_blocking`

## Requirements
- R1: After reset the state word is 0 and the external-interrupt, NMI and SMI blocking flags are low.
- R2: A retire of kind 1 (interrupt enable) while word bit 0 is clear sets bit 0 (interrupt-enable shadow) and raises the external-interrupt block. The next retire of any kind clears bit 0.
- R3: A retire of kind 1 while bit 0 is already set leaves bit 0 cleared; the shadow is not extended.
- R4: A retire of kind 2 (stack-segment load) sets bit 1 (stack-load shadow) and raises the external-interrupt block. Any later retire of a kind other than 2 clears bit 1.
- R5: In a cycle with no retire and no entry load, bits 0 and 1 keep their values.
- R6: SMI delivery sets bit 2 (SMI blocked) and bit 3 (NMI blocked). A retire of kind 4 (return from SMM) clears both.
- R7: NMI delivery sets bit 3. A retire of kind 3 (interrupt return) clears bit 3 and leaves bit 2 unchanged. Kinds 0, 5, 6 and 7 act as ordinary instructions.
- R8: When a delivery arrives in the same cycle as a retire that would clear the bit it sets, the bit ends up set.
- R9: The INIT block is high when the mode input shows root operation or the SMM input is high, and low otherwise.
- R10: The SIPI block is high exactly when the mode input shows root operation.
- R11: An entry load replaces the whole word with the entry value on the next edge, taking priority over retires and deliveries in the same cycle.
- R12: The save port always shows the current state word, and the NMI and SMI blocks equal bits 3 and 2 of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_vld | input | 1 | One instruction retired this cycle |
| retire_kind | input | 3 | 0 other, 1 interrupt enable, 2 stack-segment load, 3 interrupt return, 4 return from SMM |
| nmi_taken | input | 1 | NMI delivered this cycle |
| smi_taken | input | 1 | SMI delivered this cycle |
| guest_mode | input | 1 | 1 = non-root (guest), 0 = root |
| smm_active | input | 1 | Core is in system management mode |
| entry_load | input | 1 | VM entry: load the state word |
| entry_word | input | 4 | State word to load on entry |
| save_word | output | 4 | Live state word for VM exit capture |
| blk_extint | output | 1 | External interrupts blocked |
| blk_nmi | output | 1 | NMI blocked |
| blk_smi | output | 1 | SMI blocked |
| blk_init | output | 1 | INIT blocked |
| blk_sipi | output | 1 | SIPI blocked |

## Verification
The bench targets back-to-back interrupt-enable retires. A design that re-arms the shadow there would keep interrupts masked through a run of such instructions. It also checks that shadows hold across idle cycles, which catches a design that times them out by clock. Delivery in the same cycle as a clearing return is driven on purpose: a design with the wrong priority would drop a fresh NMI or SMI block and allow nested delivery. Entry loads collide with retires and deliveries, and long random runs with all modes compare every flag each cycle against a bench model.

// File: rtl/gbs_pkg.sv
package gbs_pkg;
  localparam int unsigned WORD_W  = 4;
  localparam int unsigned KIND_W  = 3;
  localparam int unsigned B_STI   = 0;
  localparam int unsigned B_MSS   = 1;
  localparam int unsigned B_SMI   = 2;
  localparam int unsigned B_NMI   = 3;

  typedef enum logic [KIND_W-1:0] {
    K_OTHER = 3'd0,
    K_STI   = 3'd1,
    K_MSS   = 3'd2,
    K_IRET  = 3'd3,
    K_RSM   = 3'd4
  } kind_e;

  typedef struct packed {
    logic nmi;
    logic smi;
    logic mss;
    logic sti;
  } word_t;

  // interrupt-enable shadow after a retire: armed only from the idle state
  function automatic logic sti_after(input logic [KIND_W-1:0] kind, input logic cur);
    return (kind == K_STI) && !cur;
  endfunction

  // stack-load shadow after a retire
  function automatic logic mss_after(input logic [KIND_W-1:0] kind);
    return kind == K_MSS;
  endfunction

  // persistent block: clear by matching return, then set by delivery
  function automatic logic hold_after(input logic cur, input logic clr, input logic set);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/gbs_shadow.sv
module gbs_shadow
  import gbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_vld,
  input  logic [KIND_W-1:0] retire_kind,
  input  logic              load,
  input  logic              load_sti,
  input  logic              load_mss,
  output logic              sti_sh,
  output logic              mss_sh,
  output logic              retire_evt
);
  logic sti_d, mss_d;

  assign retire_evt = retire_vld & ~load;

  always_comb begin
    sti_d = sti_sh;
    mss_d = mss_sh;
    if (load) begin
      sti_d = load_sti;
      mss_d = load_mss;
    end else if (retire_vld) begin
      sti_d = sti_after(retire_kind, sti_sh);
      mss_d = mss_after(retire_kind);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sti_sh <= 1'b0;
      mss_sh <= 1'b0;
    end else begin
      sti_sh <= sti_d;
      mss_sh <= mss_d;
    end
  end

  a_r3_no_extend: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_evt && retire_kind == K_STI && sti_sh) |=> !sti_sh);
  a_r2_sti_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_evt && retire_kind == K_STI && !sti_sh) |=> sti_sh);
  a_r4_other_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_evt && retire_kind == K_OTHER) |=> (!sti_sh && !mss_sh));
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire_vld && !load) |=> ($stable(sti_sh) && $stable(mss_sh)));
endmodule

// File: rtl/gbs_hold.sv
module gbs_hold
  import gbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_evt,
  input  logic [KIND_W-1:0] retire_kind,
  input  logic              nmi_taken,
  input  logic              smi_taken,
  input  logic              load,
  input  logic              load_smi,
  input  logic              load_nmi,
  output logic              smi_blk,
  output logic              nmi_blk
);
  logic rsm_evt, iret_evt, smi_d, nmi_d;

  assign rsm_evt  = retire_evt && (retire_kind == K_RSM);
  assign iret_evt = retire_evt && (retire_kind == K_IRET);

  always_comb begin
    if (load) begin
      smi_d = load_smi;
      nmi_d = load_nmi;
    end else begin
      smi_d = hold_after(smi_blk, rsm_evt, smi_taken);
      nmi_d = hold_after(nmi_blk, rsm_evt | iret_evt, nmi_taken | smi_taken);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smi_blk <= 1'b0;
      nmi_blk <= 1'b0;
    end else begin
      smi_blk <= smi_d;
      nmi_blk <= nmi_d;
    end
  end

  a_r6_smi_sets_both: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_taken && !load) |=> (smi_blk && nmi_blk));
  a_r8_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_taken && iret_evt) |=> nmi_blk);
  a_r7_iret_keeps_smi: assert property (@(posedge clk) disable iff (!rst_n)
    (iret_evt && !nmi_taken && !smi_taken) |=> (!nmi_blk && smi_blk == $past(smi_blk)));
  a_r6_rsm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rsm_evt && !nmi_taken && !smi_taken) |=> (!nmi_blk && !smi_blk));
endmodule

// File: rtl/gbs_mode_gate.sv
module gbs_mode_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic guest_mode,
  input  logic smm_active,
  output logic blk_init,
  output logic blk_sipi
);
  always_comb begin
    blk_sipi = ~guest_mode;
    blk_init = ~guest_mode | smm_active;
  end

  a_r10_sipi_implies_init: assert property (@(posedge clk) disable iff (!rst_n)
    blk_sipi |-> blk_init);
  a_r9_guest_open: assert property (@(posedge clk) disable iff (!rst_n)
    (guest_mode && !smm_active) |-> (!blk_init && !blk_sipi));
endmodule

// File: rtl/guest_intr_blocking.sv
module guest_intr_blocking
  import gbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_vld,
  input  logic [KIND_W-1:0] retire_kind,
  input  logic              nmi_taken,
  input  logic              smi_taken,
  input  logic              guest_mode,
  input  logic              smm_active,
  input  logic              entry_load,
  input  logic [WORD_W-1:0] entry_word,
  output logic [WORD_W-1:0] save_word,
  output logic              blk_extint,
  output logic              blk_nmi,
  output logic              blk_smi,
  output logic              blk_init,
  output logic              blk_sipi
);
  word_t ld_w, cur_w;
  logic  retire_evt;

  assign ld_w = word_t'(entry_word);

  gbs_shadow u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .retire_vld (retire_vld),
    .retire_kind(retire_kind),
    .load       (entry_load),
    .load_sti   (ld_w.sti),
    .load_mss   (ld_w.mss),
    .sti_sh     (cur_w.sti),
    .mss_sh     (cur_w.mss),
    .retire_evt (retire_evt)
  );

  gbs_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .retire_evt (retire_evt),
    .retire_kind(retire_kind),
    .nmi_taken  (nmi_taken),
    .smi_taken  (smi_taken),
    .load       (entry_load),
    .load_smi   (ld_w.smi),
    .load_nmi   (ld_w.nmi),
    .smi_blk    (cur_w.smi),
    .nmi_blk    (cur_w.nmi)
  );

  gbs_mode_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .guest_mode (guest_mode),
    .smm_active (smm_active),
    .blk_init   (blk_init),
    .blk_sipi   (blk_sipi)
  );

  assign save_word  = cur_w;
  assign blk_extint = cur_w.sti | cur_w.mss;
  assign blk_nmi    = cur_w.nmi;
  assign blk_smi    = cur_w.smi;

  a_r11_entry_load: assert property (@(posedge clk) disable iff (!rst_n)
    entry_load |=> (save_word == $past(entry_word)));
  a_r12_smi_implies_nmi_after_delivery: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_taken && !entry_load) |=> (blk_smi && blk_nmi && save_word[B_SMI] && save_word[B_NMI]));
endmodule

// File: tb/guest_intr_blocking_test.sv
module guest_intr_blocking_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       retire_vld = 1'b0;
  logic [2:0] retire_kind = 3'd0;
  logic       nmi_taken = 1'b0, smi_taken = 1'b0;
  logic       guest_mode = 1'b0, smm_active = 1'b0;
  logic       entry_load = 1'b0;
  logic [3:0] entry_word = 4'd0;
  logic [3:0] save_word;
  logic       blk_extint, blk_nmi, blk_smi, blk_init, blk_sipi;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [3:0] model = 4'd0;

  always #5 clk = ~clk;

  guest_intr_blocking uut (
    .clk(clk), .rst_n(rst_n), .retire_vld(retire_vld), .retire_kind(retire_kind),
    .nmi_taken(nmi_taken), .smi_taken(smi_taken), .guest_mode(guest_mode),
    .smm_active(smm_active), .entry_load(entry_load), .entry_word(entry_word),
    .save_word(save_word), .blk_extint(blk_extint), .blk_nmi(blk_nmi),
    .blk_smi(blk_smi), .blk_init(blk_init), .blk_sipi(blk_sipi)
  );

  // Bench model of the word, written from the requirements
  function automatic logic [3:0] predict(input logic [3:0] w, input logic rv, input logic [2:0] k,
                                         input logic nmi, input logic smi, input logic ld,
                                         input logic [3:0] lw);
    logic [3:0] r;
    if (ld) return lw;                       // R11
    r = w;
    if (rv) begin
      r[0] = (k == 3'd1) ? ~w[0] : 1'b0;     // R2, R3
      r[1] = (k == 3'd2);                    // R4
      if (k == 3'd3) r[3] = 1'b0;            // R7
      if (k == 3'd4) r[3:2] = 2'b00;         // R6
    end
    if (smi) r[3:2] = 2'b11;                 // R6, R8
    if (nmi) r[3] = 1'b1;                    // R7, R8
    return r;
  endfunction

  task automatic cmp(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    cmp({tag, " R12 save_word"}, save_word, model);
    cmp({tag, " R2 extint"}, {3'b0, blk_extint}, {3'b0, model[0] | model[1]});
    cmp({tag, " R7 nmi"}, {3'b0, blk_nmi}, {3'b0, model[3]});
    cmp({tag, " R6 smi"}, {3'b0, blk_smi}, {3'b0, model[2]});
    cmp({tag, " R9 init"}, {3'b0, blk_init}, {3'b0, ~guest_mode | smm_active});
    cmp({tag, " R10 sipi"}, {3'b0, blk_sipi}, {3'b0, ~guest_mode});
  endtask

  // one cycle: drive at negedge, check the word left by the previous edge, advance model
  task automatic step(input string tag, input logic rv, input logic [2:0] k, input logic nmi,
                      input logic smi, input logic ld, input logic [3:0] lw,
                      input logic gm, input logic sm);
    @(negedge clk);
    retire_vld = rv; retire_kind = k; nmi_taken = nmi; smi_taken = smi;
    entry_load = ld; entry_word = lw; guest_mode = gm; smm_active = sm;
    #1;
    check_all(tag);
    model = predict(model, rv, k, nmi, smi, ld, lw);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 3'd0, 0, 0, 0, 4'd0, 1, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check_all("R1 in reset");
    rst_n = 1'b1;
    idle("R1 after reset");

    // R2: shadow set, then cleared by next retire
    step("R2 arm", 1, 3'd1, 0, 0, 0, 4'd0, 1, 0);
    idle("R2 armed");
    idle("R5 hold idle");            // R5: shadow survives idle cycles
    step("R2 clear", 1, 3'd0, 0, 0, 0, 4'd0, 1, 0);
    idle("R2 cleared");
    // R3: back-to-back STI
    step("R3 first", 1, 3'd1, 0, 0, 0, 4'd0, 1, 0);
    step("R3 second", 1, 3'd1, 0, 0, 0, 4'd0, 1, 0);
    step("R3 third", 1, 3'd1, 0, 0, 0, 4'd0, 1, 0);
    step("R3 other", 1, 3'd0, 0, 0, 0, 4'd0, 1, 0);
    // R4: stack load shadow, repeated, then cleared
    step("R4 a", 1, 3'd2, 0, 0, 0, 4'd0, 1, 0);
    step("R4 b", 1, 3'd2, 0, 0, 0, 4'd0, 1, 0);
    step("R4 clr", 1, 3'd6, 0, 0, 0, 4'd0, 1, 0);
    idle("R4 done");
    // R6: SMI then RSM
    step("R6 smi", 0, 3'd0, 0, 1, 0, 4'd0, 1, 1);
    step("R6 iret keeps smi", 1, 3'd3, 0, 0, 0, 4'd0, 1, 1);
    step("R6 rsm", 1, 3'd4, 0, 0, 0, 4'd0, 1, 0);
    idle("R6 done");
    // R7: NMI then IRET
    step("R7 nmi", 0, 3'd0, 1, 0, 0, 4'd0, 0, 0);
    step("R7 other keeps", 1, 3'd7, 0, 0, 0, 4'd0, 0, 0);
    step("R7 iret", 1, 3'd3, 0, 0, 0, 4'd0, 0, 0);
    idle("R7 done");
    // R8: delivery wins against same-cycle clear
    step("R8 nmi+iret", 1, 3'd3, 1, 0, 0, 4'd0, 1, 0);
    step("R8 smi+rsm", 1, 3'd4, 0, 1, 0, 4'd0, 1, 0);
    idle("R8 result");
    // R11: entry load overrides everything
    step("R11 load", 1, 3'd1, 1, 1, 1, 4'b0010, 1, 0);
    idle("R11 loaded");
    step("R11 load zero", 1, 3'd2, 0, 1, 1, 4'b0000, 1, 0);
    idle("R11 zero");
    // R9/R10 mode corners
    step("R9 root", 0, 3'd0, 0, 0, 0, 4'd0, 0, 0);
    step("R9 guest smm", 0, 3'd0, 0, 0, 0, 4'd0, 1, 1);
    step("R10 guest", 0, 3'd0, 0, 0, 0, 4'd0, 1, 0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic rv, nmi, smi, ld;
      logic [2:0] k;
      rv  = ($urandom % 3) != 0;
      k   = 3'($urandom % 8);
      if (($urandom % 4) != 0) k = 3'($urandom % 5);
      nmi = ($urandom % 8) == 0;
      smi = ($urandom % 12) == 0;
      ld  = ($urandom % 16) == 0;
      step("random", rv, k, nmi, smi, ld, 4'($urandom), 1'($urandom), ($urandom % 4) == 0);
    end
    idle("random end");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule